// File: doc/BRIEF.md
# Receive DMA Channel Controller

This block is one receive-direction DMA channel. Bytes arriving on a strobed byte input are staged in a four-entry FIFO and then written, one memory write per byte, into a circular buffer. The buffer runs from a base address to a bound address, and the write address comes from a pointer that software can read and preset. Once software sets the run bit, the channel keeps transferring until software clears that bit. Software can work out how many bytes have arrived by comparing the pointer with the value it had earlier.

The channel signals software in one of three ways. In periodic mode it raises an interrupt flag after every n accepted bytes and then reloads its working counter by itself. In timeout mode it raises the flag when the line has been idle for a programmed number of cycles after a byte arrived. In quiet mode it raises no flag at all. The flag stays set until software writes a one to clear it. The interrupt output is the flag gated by an enable bit.

Top module: `rx_dma_chan`

## Requirements
- R1: After reset, every register reads zero, `irq` and `mem_req` are low and the FIFO is empty.
- R2: Registers are at these `reg_addr` values: 0 control, 1 segment, 2 base, 3 bound, 4 pointer, 5 byte count, 6 FIFO status/control, 7 idle timeout, 8 flag. Control bit 0 is run, bits 2:1 are the mode (01 periodic, 10 timeout, 00 or 11 quiet) and bit 3 is interrupt enable. Control reads back only bits 3:0. Segment, base, bound, pointer, byte count and timeout read back the 16-bit value written.
- R3: While running with the FIFO not empty, `mem_req` is high. `mem_addr` equals the pointer, `mem_seg` equals the segment register, and `mem_data` is the oldest staged byte, so bytes leave in arrival order. Each cycle with `mem_req` and `mem_ack` high pops one byte and advances the pointer by one.
- R4: An acknowledged write at the pointer value equal to the bound sets the pointer to the base.
- R5: The FIFO holds four bytes, and the FIFO register reads the fill level in bits 2:0. A byte that arrives while the FIFO is full is dropped and sets the overrun bit (bit 3). Writing a one to bit 3 clears the overrun bit, and writing a one to bit 4 empties the FIFO.
- R6: In periodic mode the flag is set on every n-th accepted byte, where n is the byte count register. The working counter reloads itself, so software writes n only once.
- R7: In timeout mode with timeout value T, the flag is set T clock edges after the edge that accepted the last byte. An idle line raises the flag at most once until another byte arrives.
- R8: In quiet mode the flag is never set.
- R9: `irq` is high exactly when the flag (read as bit 0 of register 8) and the enable bit are both set. The flag holds until a write of 1 to bit 0 of register 8.
- R10: With run clear, `mem_req` stays low and incoming bytes are not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| rx_valid | input | 1 | Incoming byte strobe |
| rx_byte | input | 8 | Incoming byte |
| mem_req | output | 1 | Memory write request |
| mem_ack | input | 1 | Memory write accepted |
| mem_seg | output | 16 | Segment for the write |
| mem_addr | output | 16 | Address of the write |
| mem_data | output | 8 | Byte being written |
| irq | output | 1 | Gated interrupt flag |

## Verification
The bound checker checks the pointer's step and wrap on every acknowledged write, that no request appears while stopped, and that a full FIFO drops a new byte and flags overrun. It also checks that the flag cannot rise in quiet mode and that the flag stays set until software clears it. Only the bench scenarios can show the things that depend on history: the byte order in memory, the exact byte that completes each periodic group, the exact idle cycle on which the timeout fires, and that an idle line raises no second timeout.

// File: rtl/rx_dma_chan.sv
module rx_dma_chan #(
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [3:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  output logic          mem_req,
  input  logic          mem_ack,
  output logic [DW-1:0] mem_seg,
  output logic [DW-1:0] mem_addr,
  output logic [7:0]    mem_data,
  output logic          irq
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [3:0] A_CTRL = 4'd0, A_SEG = 4'd1, A_BASE = 4'd2, A_BOUND = 4'd3,
                         A_PTR = 4'd4, A_CNT = 4'd5, A_FIFO = 4'd6, A_TO = 4'd7, A_FLAG = 4'd8;

  logic [3:0]    ctrl_r;
  logic [DW-1:0] seg_r, base_r, bound_r, ptr, cnt_rld, cnt, to_r, tcnt;
  logic          armed, ovr, flag;
  logic [7:0]    fifo [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [LW-1:0] level;

  wire run  = ctrl_r[0];
  wire [1:0] mode = ctrl_r[2:1];
  wire ien  = ctrl_r[3];
  wire full = (level == LW'(DEPTH));
  wire push = run && rx_valid && !full;
  wire pop  = mem_req && mem_ack;
  wire wr_ctrl  = reg_we && reg_addr == A_CTRL;
  wire wr_cnt   = reg_we && reg_addr == A_CNT;
  wire wr_fifo  = reg_we && reg_addr == A_FIFO;
  wire flush    = wr_fifo && reg_wdata[4];
  wire per_hit  = push && mode == 2'b01 && cnt <= DW'(1);
  wire to_hit   = mode == 2'b10 && armed && !push && to_r != '0 && tcnt == to_r - DW'(1);

  assign mem_req  = run && level != '0;
  assign mem_seg  = seg_r;
  assign mem_addr = ptr;
  assign mem_data = fifo[rp];
  assign irq      = flag && ien;

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = DW'(ctrl_r);
      A_SEG:   reg_rdata = seg_r;
      A_BASE:  reg_rdata = base_r;
      A_BOUND: reg_rdata = bound_r;
      A_PTR:   reg_rdata = ptr;
      A_CNT:   reg_rdata = cnt_rld;
      A_FIFO:  reg_rdata = DW'({ovr, 3'(level)});
      A_TO:    reg_rdata = to_r;
      A_FLAG:  reg_rdata = DW'(flag);
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_r <= '0; seg_r <= '0; base_r <= '0; bound_r <= '0; to_r <= '0;
      cnt_rld <= '0; cnt <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_CTRL:  ctrl_r  <= reg_wdata[3:0];
        A_SEG:   seg_r   <= reg_wdata;
        A_BASE:  base_r  <= reg_wdata;
        A_BOUND: bound_r <= reg_wdata;
        A_TO:    to_r    <= reg_wdata;
        A_CNT:   begin cnt_rld <= reg_wdata; cnt <= reg_wdata; end
        default: ;
      endcase
      if (!wr_cnt && push && mode == 2'b01) cnt <= per_hit ? cnt_rld : cnt - DW'(1);
    end else if (push && mode == 2'b01) begin
      cnt <= per_hit ? cnt_rld : cnt - DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else if (reg_we && reg_addr == A_PTR) ptr <= reg_wdata;
    else if (pop) ptr <= (ptr == bound_r) ? base_r : ptr + DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0; tcnt <= '0;
    end else if (!run || mode != 2'b10) begin
      armed <= 1'b0; tcnt <= '0;
    end else if (push) begin
      armed <= 1'b1; tcnt <= '0;
    end else if (to_hit) begin
      armed <= 1'b0;
    end else if (armed) begin
      tcnt <= tcnt + DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else if (per_hit || to_hit) flag <= 1'b1;
    else if (reg_we && reg_addr == A_FLAG && reg_wdata[0]) flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr <= 1'b0;
    else if (run && rx_valid && full) ovr <= 1'b1;
    else if (wr_fifo && reg_wdata[3]) ovr <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; level <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; level <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
      level <= level + LW'(push) - LW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) fifo[wp] <= rx_byte;
  end

  logic unused_ok;
  assign unused_ok = wr_ctrl;
endmodule

// File: rtl/rx_dma_chan_chk.sv
module rx_dma_chan_chk #(
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  parameter int LW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic [1:0]    mode,
  input logic          reg_we,
  input logic          rx_valid,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [DW-1:0] ptr,
  input logic [DW-1:0] base_r,
  input logic [DW-1:0] bound_r,
  input logic [LW-1:0] level,
  input logic          ovr,
  input logic          flag
);
  AST_REQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> run); // R10
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && ptr != bound_r && !reg_we |=> ptr == $past(ptr) + DW'(1)); // R3
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && ptr == bound_r && !reg_we |=> ptr == $past(base_r)); // R4
  AST_OVERRUN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    run && rx_valid && level == LW'(DEPTH) && !(mem_req && mem_ack) && !reg_we
    |=> ovr && level == LW'(DEPTH)); // R5
  AST_LEVEL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) level <= LW'(DEPTH)); // R5
  AST_QUIET_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(mode) == 2'b01 || $past(mode) == 2'b10); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !reg_we |=> flag); // R9
endmodule

bind rx_dma_chan rx_dma_chan_chk #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) chk (
  .clk(clk), .rst_n(rst_n), .run(run), .mode(mode), .reg_we(reg_we),
  .rx_valid(rx_valid), .mem_req(mem_req), .mem_ack(mem_ack), .ptr(ptr),
  .base_r(base_r), .bound_r(bound_r), .level(level), .ovr(ovr), .flag(flag)
);

// File: tb/rx_dma_chan_test.sv
module rx_dma_chan_test;
  localparam int CLK_P = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic rx_valid = 1'b0;
  logic [7:0] rx_byte = '0, mem_data;
  logic mem_req, mem_ack, irq;
  logic auto_ack = 1'b0, man_ack = 1'b0;
  logic [15:0] mem_seg, mem_addr;
  int tests = 0, fails = 0;
  bit done = 0;

  assign mem_ack = auto_ack ? mem_req : man_ack;
  always #(CLK_P/2) clk = ~clk;

  rx_dma_chan uut (.*);

  // {addr, write value, expected readback}
  localparam logic [47:0] VEC [9] = '{
    {16'd0, 16'hFFF6, 16'h0006}, {16'd1, 16'hABCD, 16'hABCD},
    {16'd2, 16'h1234, 16'h1234}, {16'd3, 16'h5678, 16'h5678},
    {16'd4, 16'h2222, 16'h2222}, {16'd5, 16'h0007, 16'h0007},
    {16'd7, 16'h0040, 16'h0040}, {16'd6, 16'h0000, 16'h0000},
    {16'd0, 16'h0000, 16'h0000}};

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic ack_one(string req, logic [15:0] a, logic [7:0] b);
    @(negedge clk);
    chk(req, 16'(mem_req), 16'd1);
    chk(req, mem_addr, a);
    chk(req, 16'(mem_data), 16'(b));
    man_ack = 1'b1;
    @(negedge clk); man_ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 9; a++) begin rd(4'(a), v); chk("R1", v, 16'h0); end
    chk("R1", 16'(mem_req), 0); chk("R1", 16'(irq), 0);

    // R2 register table
    for (int i = 0; i < 9; i++) begin
      wr(VEC[i][43:32], VEC[i][31:16]);
      rd(VEC[i][43:32], v); chk("R2", v, VEC[i][15:0]);
    end

    // R3 / R4 order, address, wrap
    wr(2, 16'h0010); wr(3, 16'h0012); wr(4, 16'h0010); wr(1, 16'h00AB);
    wr(0, 16'h0001);
    send(8'hA1); send(8'hA2); send(8'hA3); send(8'hA4);
    chk("R3", mem_seg, 16'h00AB);
    ack_one("R3", 16'h0010, 8'hA1); ack_one("R3", 16'h0011, 8'hA2);
    ack_one("R4", 16'h0012, 8'hA3); ack_one("R4", 16'h0010, 8'hA4);
    rd(4, v); chk("R4", v, 16'h0011);
    rd(6, v); chk("R3", v, 16'h0000);

    // R5 overrun
    send(8'hB0); send(8'hB1); send(8'hB2); send(8'hB3);
    rd(6, v); chk("R5", v, 16'h0004);
    send(8'hB4);
    rd(6, v); chk("R5", v, 16'h000C);
    ack_one("R5", 16'h0011, 8'hB0); ack_one("R5", 16'h0012, 8'hB1);
    ack_one("R5", 16'h0010, 8'hB2); ack_one("R5", 16'h0011, 8'hB3);
    @(negedge clk); chk("R5", 16'(mem_req), 0);
    wr(6, 16'h0008); rd(6, v); chk("R5", v, 16'h0000);
    send(8'hC0); send(8'hC1); wr(6, 16'h0010); rd(6, v); chk("R5", v, 16'h0000);

    // R6 / R9 periodic
    auto_ack = 1'b1;
    wr(5, 16'd3); wr(0, 16'h000B);
    send(8'h01); send(8'h02); chk("R6", 16'(irq), 0);
    send(8'h03); chk("R6", 16'(irq), 1);
    wr(8, 16'h0001); chk("R9", 16'(irq), 0);
    send(8'h04); send(8'h05); chk("R6", 16'(irq), 0);
    send(8'h06); chk("R6", 16'(irq), 1);
    repeat (5) @(negedge clk); chk("R9", 16'(irq), 1);
    wr(8, 16'h0001);
    wr(0, 16'h0003);
    send(8'h07); send(8'h08); send(8'h09);
    chk("R9", 16'(irq), 0); rd(8, v); chk("R9", v, 16'h0001);
    wr(0, 16'h000B); chk("R9", 16'(irq), 1);
    wr(8, 16'h0001);

    // R7 timeout
    wr(7, 16'd5); wr(0, 16'h000D);
    repeat (20) @(negedge clk); chk("R7", 16'(irq), 0);
    send(8'h11);
    repeat (4) @(negedge clk); chk("R7", 16'(irq), 0);
    @(negedge clk); chk("R7", 16'(irq), 1);
    wr(8, 16'h0001);
    repeat (20) @(negedge clk); chk("R7", 16'(irq), 0);
    send(8'h12); send(8'h13);
    repeat (4) @(negedge clk); chk("R7", 16'(irq), 0);
    @(negedge clk); chk("R7", 16'(irq), 1);
    wr(8, 16'h0001);

    // R8 quiet mode
    wr(0, 16'h0009);
    for (int i = 0; i < 8; i++) send(8'(i));
    repeat (20) @(negedge clk);
    rd(8, v); chk("R8", v, 16'h0000); chk("R8", 16'(irq), 0);

    // R10 stopped
    auto_ack = 1'b0;
    wr(0, 16'h0000);
    send(8'hEE); send(8'hEF);
    rd(6, v); chk("R10", v, 16'h0000); chk("R10", 16'(mem_req), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule